// File: doc/BRIEF.md
# Sticky Shared-Pin Chip-Select Multiplexer

This block lets two package pins that normally carry alternate functions, such as an upper address bit or a DMA handshake, be taken over for an external peripheral. After the takeover one pin is an active-low chip select decoded from the host I/O bus. The other pin carries the peripheral's interrupt back to the host. The takeover happens only when a board strap pin reads low and software has loaded a non-zero base address. Once it has happened, it holds until the next device reset.

The chip select is decoded from the address bus and the active-low read and write strobes. It covers an aligned window of eight I/O locations selected by the base register. The peripheral interrupt is brought into the clock domain through a synchronizer. Its output level is then set by a polarity bit. Two configuration paths can write that bit: a hardware-configuration byte and a control register.

Top module: `shared_pin_cs_mux`

## Requirements
- R1: When the pins are in the peripheral role, `pin_a_o` (active low) is 0 exactly when at least one of `ior_n_i` or `iow_n_i` is 0 and `addr_i[15:3]` equals the base register bits [15:3]. Otherwise it is 1. The output follows the bus inputs in the same cycle, with no clock edge in between.
- R2: The decoded window holds the eight addresses from base[15:3]*8 to base[15:3]*8+7. The address just below the window and the address just above it leave `pin_a_o` at 1.
- R3: The role switches at a clock edge where `strap_n_i` is 0 and the registered base is non-zero. A base write takes effect at the edge where `base_we_i` is 1, so the switch comes one edge after that write at the earliest.
- R4: After the switch, the peripheral role holds until `rst_n` is asserted, even if the base is later written to zero or `strap_n_i` goes high. Later base writes still move the decoded window.
- R5: In the alternate role, `pin_a_o` equals `alt_a_i` and `pin_b_o` equals `alt_b_i`, whatever the strobes, address and interrupt are doing.
- R6: In the peripheral role, `pin_b_o` is the inverted synchronized interrupt when the polarity bit is 0 (active low) and the synchronized interrupt itself when the bit is 1.
- R7: The polarity bit is loaded from `cfg_pol_i` when `cfg_pol_we_i` is 1 and from `reg_pol_i` when `reg_pol_we_i` is 1. When both are written in the same cycle, `reg_pol_i` wins.
- R8: A change on `per_irq_i` reaches `pin_b_o` after exactly two rising clock edges.
- R9: No switch happens while `strap_n_i` is 1, even with a non-zero base. No switch happens with a zero base, even while `strap_n_i` is 0.
- R10: An asynchronous reset clears the base register, the polarity bit, the synchronizer and the role, returning both pins to their alternate functions at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_n_i | input | 1 | Board strap; low permits the takeover |
| addr_i | input | 16 | Host I/O address |
| ior_n_i | input | 1 | Host I/O read strobe, active low |
| iow_n_i | input | 1 | Host I/O write strobe, active low |
| base_we_i | input | 1 | Base register write enable |
| base_wdata_i | input | 16 | Base register write value |
| cfg_pol_we_i | input | 1 | Polarity write via configuration byte path |
| cfg_pol_i | input | 1 | Polarity value from configuration byte path |
| reg_pol_we_i | input | 1 | Polarity write via control register path |
| reg_pol_i | input | 1 | Polarity value from control register path |
| alt_a_i | input | 1 | Alternate-function value for pin A |
| alt_b_i | input | 1 | Alternate-function value for pin B |
| per_irq_i | input | 1 | Peripheral interrupt, asynchronous |
| pin_a_o | output | 1 | Shared pin A: chip select or alternate |
| pin_b_o | output | 1 | Shared pin B: interrupt or alternate |

## Verification
The bench builds the block with its defaults: a 16-bit address, a window of 2^3 locations and a two-stage synchronizer. With these values, random addresses drawn from a small span around the current base land on both window edges and on their outside neighbours often. The two-edge interrupt latency can also be checked cycle by cycle. Directed steps cover the one-edge gap between the base write and the switch, the stickiness after the base is cleared and the strap is released, and the case where both polarity paths are written in the same cycle.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic {
        ROLE_ALT    = 1'b0,
        ROLE_PERIPH = 1'b1
    } pin_role_t;

    function automatic logic apply_pol(input logic level, input logic active_high);
        return active_high ? level : ~level;
    endfunction

endpackage

// File: rtl/spm_win_decode.sv
module spm_win_decode #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned WIN_BITS = 3
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic               ior_n_i,
    input  logic               iow_n_i,
    input  spm_pkg::pin_role_t role_i,
    output logic               sel_n_o
);
    localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((64'd1 << WIN_BITS) - 64'd1);
    localparam logic [ADDR_W-1:0] HIGH_MASK = ~LOW_MASK;

    logic hit;
    logic strobe;

    always_comb begin
        hit     = ((addr_i ^ base_i) & HIGH_MASK) == '0;
        strobe  = !ior_n_i || !iow_n_i;
        sel_n_o = !((role_i == spm_pkg::ROLE_PERIPH) && hit && strobe);
    end

endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_n_i,
    input  logic               base_we_i,
    input  logic [ADDR_W-1:0]  base_wdata_i,
    input  logic               cfg_pol_we_i,
    input  logic               cfg_pol_i,
    input  logic               reg_pol_we_i,
    input  logic               reg_pol_i,
    output logic [ADDR_W-1:0]  base_o,
    output logic               pol_o,
    output spm_pkg::pin_role_t role_o
);
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic               pol;
        spm_pkg::pin_role_t role;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (base_we_i) begin
            st_d.base = base_wdata_i;
        end
        if (reg_pol_we_i) begin
            st_d.pol = reg_pol_i;
        end else if (cfg_pol_we_i) begin
            st_d.pol = cfg_pol_i;
        end
        if (st_q.role == spm_pkg::ROLE_ALT && !strap_n_i && st_q.base != '0) begin
            st_d.role = spm_pkg::ROLE_PERIPH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.base;
    assign pol_o  = st_q.pol;
    assign role_o = st_q.role;

    assert_switch_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.role == spm_pkg::ROLE_PERIPH) |-> $past(!strap_n_i && st_q.base != '0))
        else $error("role switched without strap low and non-zero base");

    assert_role_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.role == spm_pkg::ROLE_PERIPH) |=> (st_q.role == spm_pkg::ROLE_PERIPH))
        else $error("peripheral role dropped without reset");

    assert_pol_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.pol) |-> $past(cfg_pol_we_i || reg_pol_we_i))
        else $error("polarity changed without a write");

endmodule

// File: rtl/spm_irq_path.sv
module spm_irq_path #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic pol_i,
    output logic irq_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t sy_d, sy_q;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_comb begin
                sy_d.chain = {sy_q.chain[SYNC_STAGES-2:0], irq_i};
            end
        end else begin : g_single
            always_comb begin
                sy_d.chain = irq_i;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign irq_o = spm_pkg::apply_pol(sy_q.chain[SYNC_STAGES-1], pol_i);

endmodule

// File: rtl/shared_pin_cs_mux.sv
module shared_pin_cs_mux #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned WIN_BITS    = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ior_n_i,
    input  logic              iow_n_i,
    input  logic              base_we_i,
    input  logic [ADDR_W-1:0] base_wdata_i,
    input  logic              cfg_pol_we_i,
    input  logic              cfg_pol_i,
    input  logic              reg_pol_we_i,
    input  logic              reg_pol_i,
    input  logic              alt_a_i,
    input  logic              alt_b_i,
    input  logic              per_irq_i,
    output logic              pin_a_o,
    output logic              pin_b_o
);
    logic [ADDR_W-1:0]  base;
    logic               pol;
    spm_pkg::pin_role_t role;
    logic               sel_n;
    logic               irq_lvl;

    spm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_n_i    (strap_n_i),
        .base_we_i    (base_we_i),
        .base_wdata_i (base_wdata_i),
        .cfg_pol_we_i (cfg_pol_we_i),
        .cfg_pol_i    (cfg_pol_i),
        .reg_pol_we_i (reg_pol_we_i),
        .reg_pol_i    (reg_pol_i),
        .base_o       (base),
        .pol_o        (pol),
        .role_o       (role)
    );

    spm_win_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
        .addr_i  (addr_i),
        .base_i  (base),
        .ior_n_i (ior_n_i),
        .iow_n_i (iow_n_i),
        .role_i  (role),
        .sel_n_o (sel_n)
    );

    spm_irq_path #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (per_irq_i),
        .pol_i (pol),
        .irq_o (irq_lvl)
    );

    always_comb begin
        if (role == spm_pkg::ROLE_PERIPH) begin
            pin_a_o = sel_n;
            pin_b_o = irq_lvl;
        end else begin
            pin_a_o = alt_a_i;
            pin_b_o = alt_b_i;
        end
    end

    assert_cs_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (role == spm_pkg::ROLE_PERIPH && ior_n_i && iow_n_i) |-> pin_a_o)
        else $error("chip select active with no strobe");

    assert_cs_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (role == spm_pkg::ROLE_PERIPH && !pin_a_o) |-> ((addr_i >> WIN_BITS) == (base >> WIN_BITS)))
        else $error("chip select active outside window");

endmodule

// File: tb/shared_pin_cs_mux_test.sv
module shared_pin_cs_mux_test;
    localparam time CLK_PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strap_n;
    logic [15:0] addr;
    logic        ior_n, iow_n;
    logic        base_we;
    logic [15:0] base_wd;
    logic        cfg_we, cfg_v, reg_we, reg_v;
    logic        alt_a, alt_b, irq;
    logic        pin_a, pin_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_base;
    logic        m_pol, m_lock, m_s1, m_s2;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shared_pin_cs_mux uut (
        .clk(clk), .rst_n(rst_n), .strap_n_i(strap_n), .addr_i(addr),
        .ior_n_i(ior_n), .iow_n_i(iow_n), .base_we_i(base_we), .base_wdata_i(base_wd),
        .cfg_pol_we_i(cfg_we), .cfg_pol_i(cfg_v), .reg_pol_we_i(reg_we), .reg_pol_i(reg_v),
        .alt_a_i(alt_a), .alt_b_i(alt_b), .per_irq_i(irq),
        .pin_a_o(pin_a), .pin_b_o(pin_b)
    );

    function automatic logic exp_a();
        if (!m_lock) return alt_a;
        return !((!ior_n || !iow_n) && (addr[15:3] == m_base[15:3]));
    endfunction

    function automatic logic exp_b();
        if (!m_lock) return alt_b;
        return m_pol ? m_s2 : !m_s2;
    endfunction

    task automatic model_reset();
        m_base = '0; m_pol = 1'b0; m_lock = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic auto_chk();
        chk(m_lock ? "R1" : "R5", pin_a, exp_a());
        chk(m_lock ? "R6" : "R5", pin_b, exp_b());
    endtask

    // advance one rising edge, update the model, return at the falling edge
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            if (!m_lock && !strap_n && m_base != '0) m_lock = 1'b1;
            if (base_we) m_base = base_wd;
            if (reg_we) m_pol = reg_v;
            else if (cfg_we) m_pol = cfg_v;
            m_s2 = m_s1;
            m_s1 = irq;
        end
        @(negedge clk);
    endtask

    task automatic bus(input logic [15:0] a, input logic r, input logic w);
        addr = a; ior_n = r; iow_n = w; #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        rst_n = 1'b0; strap_n = 1'b1; addr = '0; ior_n = 1'b1; iow_n = 1'b1;
        base_we = 1'b0; base_wd = '0; cfg_we = 1'b0; cfg_v = 1'b0;
        reg_we = 1'b0; reg_v = 1'b0; alt_a = 1'b1; alt_b = 1'b0; irq = 1'b0;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R10 / R5: reset state, alternate role even with a matching strobe
        bus(16'h0000, 1'b0, 1'b1);
        chk("R10", pin_a, 1'b1);
        chk("R10", pin_b, 1'b0);
        alt_a = 1'b0; alt_b = 1'b1; #1;
        chk("R5", pin_a, 1'b0);
        chk("R5", pin_b, 1'b1);
        alt_a = 1'b1; alt_b = 1'b0;

        // R9: strap high with non-zero base
        base_we = 1'b1; base_wd = 16'h0340; step(); base_we = 1'b0;
        step(); step();
        bus(16'h0341, 1'b0, 1'b1);
        chk("R9", pin_a, 1'b1);

        // R9: strap low with zero base
        base_we = 1'b1; base_wd = 16'h0000; step(); base_we = 1'b0;
        strap_n = 1'b0; step(); step();
        bus(16'h0002, 1'b0, 1'b1);
        chk("R9", pin_a, 1'b1);

        // R3: switch one edge after the base write
        base_we = 1'b1; base_wd = 16'h0340; bus(16'h0343, 1'b0, 1'b1);
        step(); base_we = 1'b0; #1;
        chk("R3", pin_a, 1'b1);
        step(); #1;
        chk("R3", pin_a, 1'b0);

        // R2 / R1: window edges and strobes
        bus(16'h0340, 1'b0, 1'b1); chk("R2", pin_a, 1'b0);
        bus(16'h0347, 1'b0, 1'b1); chk("R2", pin_a, 1'b0);
        bus(16'h033F, 1'b0, 1'b1); chk("R2", pin_a, 1'b1);
        bus(16'h0348, 1'b0, 1'b1); chk("R2", pin_a, 1'b1);
        bus(16'h0345, 1'b1, 1'b0); chk("R1", pin_a, 1'b0);
        bus(16'h0345, 1'b1, 1'b1); chk("R1", pin_a, 1'b1);

        // R4: sticky after base cleared and strap released
        strap_n = 1'b1; base_we = 1'b1; base_wd = 16'h0000; step(); base_we = 1'b0;
        step();
        bus(16'h0005, 1'b1, 1'b0); chk("R4", pin_a, 1'b0);
        alt_a = 1'b0; bus(16'h0100, 1'b1, 1'b0); chk("R4", pin_a, 1'b1);
        alt_a = 1'b1; bus(16'h0100, 1'b1, 1'b1);

        // R8 / R6: two-edge latency, active-low default
        step(); step();
        chk("R6", pin_b, 1'b1);
        irq = 1'b1;
        step(); chk("R8", pin_b, 1'b1);
        step(); chk("R8", pin_b, 1'b0);

        // R7: both polarity paths and their priority
        cfg_we = 1'b1; cfg_v = 1'b1; step(); cfg_we = 1'b0; #1;
        chk("R7", pin_b, 1'b1);
        cfg_we = 1'b1; cfg_v = 1'b1; reg_we = 1'b1; reg_v = 1'b0; step();
        cfg_we = 1'b0; reg_we = 1'b0; #1;
        chk("R7", pin_b, 1'b0);
        reg_we = 1'b1; reg_v = 1'b1; step(); reg_we = 1'b0; #1;
        chk("R7", pin_b, 1'b1);
        irq = 1'b0; step(); step();
        chk("R6", pin_b, 1'b0);

        // random phase with a mid-run asynchronous reset
        for (int i = 0; i < 4000; i++) begin
            if (i == 2000) begin
                rst_n = 1'b0; model_reset(); #1;
                chk("R10", pin_a, alt_a);
                chk("R10", pin_b, alt_b);
                step();
                rst_n = 1'b1;
            end
            strap_n = ($urandom_range(3) == 0);
            base_we = ($urandom_range(63) == 0);
            base_wd = ($urandom_range(3) == 0) ? 16'h0000 : 16'($urandom_range(16'hFFF8));
            cfg_we  = ($urandom_range(15) == 0);
            cfg_v   = 1'($urandom_range(1));
            reg_we  = ($urandom_range(15) == 0);
            reg_v   = 1'($urandom_range(1));
            alt_a   = 1'($urandom_range(1));
            alt_b   = 1'($urandom_range(1));
            irq     = 1'($urandom_range(1));
            begin
                int off;
                off = int'($urandom_range(31)) - 12;
                bus(m_base + 16'(off), 1'($urandom_range(1)), 1'($urandom_range(1)));
            end
            auto_chk();
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule